// File: doc/BRIEF.md
# Lock-Step Mesh Processing Array

A square array of identical processing elements. A single control port issues one instruction at a time, and every element runs it in the same clock cycle. Each element has an 8-word local memory, a saturating accumulator and an operand register. The address in an instruction picks the same word in every element, so one address names a whole plane of the array. A host port writes and reads planes. A per-element activity mask decides which elements take part in arithmetic and memory writes.

Data-moving instructions act only on the operand registers. A rotation shifts the operand one place in a chosen compass direction over a torus-wired mesh. A row or column broadcast copies a vector, held along the top row or the left column of a plane, across the whole block. Data-processing instructions act on the accumulator and the memory. An instruction does either processing or movement, never both. This covers the building blocks of matrix-vector products and outer-product updates on blocked data.

Top module: `simd_mesh`

## Requirements
- R1: After reset every accumulator, operand register and memory word is zero, and every element is active.
- R2: An instruction is accepted when `in_valid` and `in_ready` are both high. `in_ready` is low in any cycle where `host_wr` or `act_wr` is high. An instruction that is not accepted, and the opcode NOP (0), change nothing. The effect of an accepted instruction is visible on the outputs in the next cycle.
- R3: LOAD (6) copies the memory word at `in_addr` into the operand register, and its sign-extended value into the accumulator, of each active element.
- R4: ADD (1) adds the sign-extended operand register to the accumulator. The result saturates to the signed 16-bit range.
- R5: MAC (2) adds the signed product of the memory word at `in_addr` and the operand register to the accumulator, saturating to the signed 16-bit range.
- R6: STORE (7) writes the accumulator, clamped to -128..127, into the memory word at `in_addr` of each active element.
- R7: ROT (3) moves every operand one place with wrap-around. Direction field 0 = north: element (i,j) takes the value from ((i+1) mod P, j). 1 = east: it takes the value from (i, (j-1) mod P). 2 = south: from ((i-1) mod P, j). 3 = west: from (i, (j+1) mod P). Row 0 is the top row.
- R8: BCAST_ROW (4) sets operand (i,j) to word `in_addr` of element (0,j). BCAST_COL (5) sets it to word `in_addr` of element (i,0).
- R9: An element whose activity bit is 0 leaves its accumulator and memory unchanged under ADD, MAC, LOAD and STORE. Its operand register still follows ROT and broadcasts.
- R10: `host_wr` writes `host_wdata` into plane `host_addr` of every element, whatever the activity mask. `host_rdata` always shows plane `host_addr`. `act_wr` loads the mask from `act_wdata`, and the new mask applies from the next cycle. All planes are flattened with element (i,j) at slot i*P+j, and slot k occupies bits [k*W +: W] (accumulators [k*2W +: 2W]).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be taken this cycle |
| in_op | input | 3 | Opcode |
| in_dir | input | 2 | Rotation direction |
| in_addr | input | AW (3) | Memory plane used by the instruction |
| host_wr | input | 1 | Host plane write strobe |
| host_addr | input | AW (3) | Host plane address, for both write and read |
| host_wdata | input | P*P*W (128) | Plane to write |
| host_rdata | output | P*P*W (128) | Plane currently addressed by the host |
| act_wr | input | 1 | Activity mask write strobe |
| act_wdata | input | P*P (16) | New activity mask, bit k for slot k |
| acc_plane | output | P*P*2W (256) | All accumulators |
| opnd_plane | output | P*P*W (128) | All operand registers |

## Verification
Assertions check four things on every cycle. A masked element's accumulator holds still. A refused instruction leaves the accumulators alone. Saturation pins the accumulator at its ceiling and clamps stored words. Eastward rotation and row broadcast land values in the right neighbour. The full correctness of each opcode can be shown only by the bench's scenarios against its behavioural model, over every element and direction. These scenarios cover column broadcast, the order between a mask write and the instruction that follows it, and collisions between host writes and instructions.

// File: rtl/simd_pkg.sv
package simd_pkg;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_ADD   = 3'd1,
    OP_MAC   = 3'd2,
    OP_ROT   = 3'd3,
    OP_BROW  = 3'd4,
    OP_BCOL  = 3'd5,
    OP_LOAD  = 3'd6,
    OP_STORE = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    DIR_N = 2'd0,
    DIR_E = 2'd1,
    DIR_S = 2'd2,
    DIR_W = 2'd3
  } dir_e;

  // one strobe per instruction kind, at most one high per cycle
  typedef struct packed {
    logic add;
    logic mac;
    logic load;
    logic store;
    logic rot;
    logic brow;
    logic bcol;
  } strobe_t;

endpackage

// File: rtl/simd_ctrl.sv
module simd_ctrl
  import simd_pkg::*;
(
  input  logic       in_valid,
  input  logic [2:0] in_op,
  input  logic       host_busy,
  output logic       in_ready,
  output strobe_t    st
);

  logic go;

  assign in_ready = !host_busy;
  assign go       = in_valid && in_ready;

  always_comb begin
    st = '0;
    if (go) begin
      unique case (op_e'(in_op))
        OP_ADD:   st.add   = 1'b1;
        OP_MAC:   st.mac   = 1'b1;
        OP_ROT:   st.rot   = 1'b1;
        OP_BROW:  st.brow  = 1'b1;
        OP_BCOL:  st.bcol  = 1'b1;
        OP_LOAD:  st.load  = 1'b1;
        OP_STORE: st.store = 1'b1;
        default:  st       = '0;
      endcase
    end
  end

endmodule

// File: rtl/simd_pe.sv
module simd_pe
  import simd_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int ACC_W = 2 * W,
  localparam int XW    = ACC_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  strobe_t                 st,
  input  logic [AW-1:0]           addr,
  input  logic                    move_en,
  input  logic signed [W-1:0]     move_x,
  input  logic                    host_we,
  input  logic [AW-1:0]           host_addr,
  input  logic signed [W-1:0]     host_d,
  input  logic                    act_we,
  input  logic                    act_d,
  output logic signed [W-1:0]     rd_word,
  output logic signed [W-1:0]     host_q,
  output logic signed [ACC_W-1:0] acc_q,
  output logic signed [W-1:0]     x_q
);

  localparam logic signed [XW-1:0]    ACC_HI = XW'((2 ** (ACC_W - 1)) - 1);
  localparam logic signed [XW-1:0]    ACC_LO = -XW'(2 ** (ACC_W - 1));
  localparam logic signed [ACC_W-1:0] WHI_A  = ACC_W'((2 ** (W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] WLO_A  = -ACC_W'(2 ** (W - 1));
  localparam logic signed [W-1:0]     WHI    = W'((2 ** (W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] ACC_TOP = ACC_W'((2 ** (ACC_W - 1)) - 1);

  logic signed [W-1:0] mem_q [DEPTH];
  logic                act_q;

  // clamp a widened sum back to the accumulator range
  function automatic logic signed [ACC_W-1:0] clamp_acc(input logic signed [XW-1:0] v);
    if (v > ACC_HI)      return ACC_W'(ACC_HI);
    else if (v < ACC_LO) return ACC_W'(ACC_LO);
    else                 return ACC_W'(v);
  endfunction

  function automatic logic signed [ACC_W-1:0] add_sat(input logic signed [ACC_W-1:0] a,
                                                      input logic signed [W-1:0] b);
    return clamp_acc(XW'(a) + XW'(b));
  endfunction

  function automatic logic signed [ACC_W-1:0] mac_sat(input logic signed [ACC_W-1:0] a,
                                                      input logic signed [W-1:0] m,
                                                      input logic signed [W-1:0] x);
    logic signed [XW-1:0] prod;
    prod = XW'(m) * XW'(x);
    return clamp_acc(XW'(a) + prod);
  endfunction

  function automatic logic signed [W-1:0] to_word(input logic signed [ACC_W-1:0] a);
    if (a > WHI_A)      return W'(WHI_A);
    else if (a < WLO_A) return W'(WLO_A);
    else                return W'(a);
  endfunction

  assign rd_word = mem_q[addr];
  assign host_q  = mem_q[host_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < DEPTH; d++) mem_q[d] <= '0;
      acc_q <= '0;
      x_q   <= '0;
      act_q <= 1'b1;
    end else begin
      if (host_we) mem_q[host_addr] <= host_d;
      if (act_we)  act_q <= act_d;
      if (act_q) begin
        if (st.load) begin
          acc_q <= ACC_W'(rd_word);
          x_q   <= rd_word;
        end
        if (st.add)   acc_q <= add_sat(acc_q, x_q);
        if (st.mac)   acc_q <= mac_sat(acc_q, rd_word, x_q);
        if (st.store) mem_q[addr] <= to_word(acc_q);
      end
      if (move_en) x_q <= move_x;
    end
  end

  // R9: a masked element keeps its accumulator
  p_masked_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |=> $stable(acc_q));

  // R5: a non-negative product cannot pull a full accumulator off its ceiling
  p_mac_ceiling_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st.mac && act_q && acc_q == ACC_TOP && (rd_word[W-1] == x_q[W-1]))
      |=> acc_q == ACC_TOP);

  // R6: an over-range accumulator is stored as the word maximum
  p_store_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st.store && act_q && acc_q > WHI_A) |=> mem_q[$past(addr)] == WHI);

endmodule

// File: rtl/simd_mesh.sv
module simd_mesh
  import simd_pkg::*;
#(
  parameter int P     = 4,
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int PP    = P * P,
  localparam int ACC_W = 2 * W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [2:0]            in_op,
  input  logic [1:0]            in_dir,
  input  logic [AW-1:0]         in_addr,
  input  logic                  host_wr,
  input  logic [AW-1:0]         host_addr,
  input  logic [PP*W-1:0]       host_wdata,
  output logic [PP*W-1:0]       host_rdata,
  input  logic                  act_wr,
  input  logic [PP-1:0]         act_wdata,
  output logic [PP*ACC_W-1:0]   acc_plane,
  output logic [PP*W-1:0]       opnd_plane
);

  strobe_t st;
  logic    move_en;

  logic signed [W-1:0]     x_pe   [PP];
  logic signed [W-1:0]     rd_pe  [PP];
  logic signed [W-1:0]     hq_pe  [PP];
  logic signed [ACC_W-1:0] acc_pe [PP];

  simd_ctrl u_ctrl (
    .in_valid  (in_valid),
    .in_op     (in_op),
    .host_busy (host_wr || act_wr),
    .in_ready  (in_ready),
    .st        (st)
  );

  assign move_en = st.rot || st.brow || st.bcol;

  for (genvar i = 0; i < P; i++) begin : g_row
    for (genvar j = 0; j < P; j++) begin : g_col
      localparam int K  = i * P + j;
      localparam int KN = ((i + 1) % P) * P + j;
      localparam int KE = i * P + ((j + P - 1) % P);
      localparam int KS = ((i + P - 1) % P) * P + j;
      localparam int KW = i * P + ((j + 1) % P);

      logic signed [W-1:0] nb_x;
      logic signed [W-1:0] mv_x;

      always_comb begin
        unique case (dir_e'(in_dir))
          DIR_N:   nb_x = x_pe[KN];
          DIR_E:   nb_x = x_pe[KE];
          DIR_S:   nb_x = x_pe[KS];
          default: nb_x = x_pe[KW];
        endcase
      end

      assign mv_x = st.rot  ? nb_x :
                    st.brow ? rd_pe[j] : rd_pe[i * P];

      simd_pe #(.W(W), .DEPTH(DEPTH)) u_pe (
        .clk       (clk),
        .rst_n     (rst_n),
        .st        (st),
        .addr      (in_addr),
        .move_en   (move_en),
        .move_x    (mv_x),
        .host_we   (host_wr),
        .host_addr (host_addr),
        .host_d    (host_wdata[K*W +: W]),
        .act_we    (act_wr),
        .act_d     (act_wdata[K]),
        .rd_word   (rd_pe[K]),
        .host_q    (hq_pe[K]),
        .acc_q     (acc_pe[K]),
        .x_q       (x_pe[K])
      );

      assign acc_plane[K*ACC_W +: ACC_W] = acc_pe[K];
      assign opnd_plane[K*W +: W]        = x_pe[K];
      assign host_rdata[K*W +: W]        = hq_pe[K];
    end
  end

  // R2: an instruction refused at the port leaves every accumulator alone
  p_refused_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> $stable(acc_plane));

  // R7: eastward step brings slot 0 into slot 1
  p_rot_east_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st.rot && dir_e'(in_dir) == DIR_E) |=> x_pe[1] == $past(x_pe[0]));

  // R8: row broadcast reaches the far corner from the top row
  p_brow_corner_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st.brow |=> x_pe[PP-1] == $past(rd_pe[P-1]));

endmodule

// File: tb/simd_mesh_tb.sv
`timescale 1ns/1ps
module simd_mesh_tb;

  localparam int P = 4, W = 8, D = 8, N = P * P, AW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [2:0] in_op = '0;
  logic [1:0] in_dir = '0;
  logic [AW-1:0] in_addr = '0, host_addr = '0;
  logic host_wr = 1'b0, act_wr = 1'b0;
  logic [N*W-1:0] host_wdata = '0, host_rdata, opnd_plane;
  logic [N-1:0] act_wdata = '0;
  logic [N*2*W-1:0] acc_plane;

  int n_vec = 0, n_bad = 0;
  int m_acc [N];
  int m_x   [N];
  int m_mem [D][N];
  bit m_act [N];

  always #4 clk = ~clk;

  simd_mesh u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_dir(in_dir), .in_addr(in_addr),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .act_wr(act_wr), .act_wdata(act_wdata),
    .acc_plane(acc_plane), .opnd_plane(opnd_plane)
  );

  function automatic int lim(int v, int lo, int hi);
    return (v < lo) ? lo : (v > hi) ? hi : v;
  endfunction

  function automatic logic [N*W-1:0] plane(int base, int stride);
    logic [N*W-1:0] r;
    for (int k = 0; k < N; k++) r[k*W +: W] = 8'(base + stride * k);
    return r;
  endfunction

  function automatic logic [N*W-1:0] flat_x();
    logic [N*W-1:0] r;
    for (int k = 0; k < N; k++) r[k*W +: W] = 8'(m_x[k]);
    return r;
  endfunction

  function automatic logic [N*2*W-1:0] flat_acc();
    logic [N*2*W-1:0] r;
    for (int k = 0; k < N; k++) r[k*16 +: 16] = 16'(m_acc[k]);
    return r;
  endfunction

  function automatic logic [N*W-1:0] flat_mem(int a);
    logic [N*W-1:0] r;
    for (int k = 0; k < N; k++) r[k*W +: W] = 8'(m_mem[a][k]);
    return r;
  endfunction

  task automatic check(string tag, string what, logic [255:0] got, logic [255:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic model(logic v, logic [2:0] op, logic [1:0] dir, int a,
                       logic hw, int ha, logic [N*W-1:0] hd, logic aw, logic [N-1:0] ad);
    int ox [N];
    for (int k = 0; k < N; k++) ox[k] = m_x[k];
    if (v && !hw && !aw) begin
      for (int i = 0; i < P; i++) begin
        for (int j = 0; j < P; j++) begin
          int k = i * P + j;
          case (op)
            3'd1: if (m_act[k]) m_acc[k] = lim(m_acc[k] + ox[k], -32768, 32767);
            3'd2: if (m_act[k]) m_acc[k] = lim(m_acc[k] + m_mem[a][k] * ox[k], -32768, 32767);
            3'd3: begin
              case (dir)
                2'd0: m_x[k] = ox[((i + 1) % P) * P + j];
                2'd1: m_x[k] = ox[i * P + (j + P - 1) % P];
                2'd2: m_x[k] = ox[((i + P - 1) % P) * P + j];
                default: m_x[k] = ox[i * P + (j + 1) % P];
              endcase
            end
            3'd4: m_x[k] = m_mem[a][j];
            3'd5: m_x[k] = m_mem[a][i * P];
            3'd6: if (m_act[k]) begin m_acc[k] = m_mem[a][k]; m_x[k] = m_mem[a][k]; end
            3'd7: if (m_act[k]) m_mem[a][k] = lim(m_acc[k], -128, 127);
            default: ;
          endcase
        end
      end
    end
    if (hw) for (int k = 0; k < N; k++) m_mem[ha][k] = int'($signed(hd[k*W +: W]));
    if (aw) for (int k = 0; k < N; k++) m_act[k] = ad[k];
  endtask

  task automatic step(string tag, logic v, logic [2:0] op, logic [1:0] dir, int a,
                      logic hw = 0, int ha = 0, logic [N*W-1:0] hd = '0,
                      logic aw = 0, logic [N-1:0] ad = '0);
    in_valid = v; in_op = op; in_dir = dir; in_addr = AW'(a);
    host_wr = hw; host_addr = AW'(ha); host_wdata = hd; act_wr = aw; act_wdata = ad;
    #1;
    check("R2", "in_ready", 256'(in_ready), 256'(!(hw || aw)));
    @(posedge clk);
    model(v, op, dir, a, hw, ha, hd, aw, ad);
    @(negedge clk);
    check(tag, "acc_plane", 256'(acc_plane), 256'(flat_acc()));
    check(tag, "opnd_plane", 256'(opnd_plane), 256'(flat_x()));
    check(tag, "host_rdata", 256'(host_rdata), 256'(flat_mem(ha)));
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < N; k++) begin
      m_acc[k] = 0; m_x[k] = 0; m_act[k] = 1'b1;
      for (int d = 0; d < D; d++) m_mem[d][k] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: all-zero state straight out of reset
    step("R1", 0, 3'd0, 0, 0, 0, 4);
    // R10: host fills planes
    step("R10", 0, 3'd0, 0, 0, 1, 0, plane(1, 1));
    step("R10", 0, 3'd0, 0, 0, 1, 1, plane(-20, 3));
    step("R10", 0, 3'd0, 0, 0, 1, 2, plane(-2, -1));
    step("R10", 0, 3'd0, 0, 0, 1, 3, plane(127, 0));
    step("R10", 0, 3'd0, 0, 0, 1, 4, plane(-128, 0));
    step("R2", 1, 3'd0, 0, 0, 0, 2);            // NOP does nothing
    step("R3", 1, 3'd6, 0, 0, 0, 0);
    step("R8", 1, 3'd4, 0, 1, 0, 1);
    step("R5", 1, 3'd2, 0, 0, 0, 0);
    step("R8", 1, 3'd5, 0, 2, 0, 2);
    step("R4", 1, 3'd1, 0, 0);
    for (int d = 0; d < 4; d++) step("R7", 1, 3'd3, 2'(d), 0);
    step("R6", 1, 3'd7, 0, 5, 0, 5);
    // R5/R6/R4 saturation corners
    step("R3", 1, 3'd6, 0, 3, 0, 3);
    for (int n = 0; n < 3; n++) step("R5", 1, 3'd2, 0, 3);
    step("R4", 1, 3'd1, 0, 0);
    step("R6", 1, 3'd7, 0, 6, 0, 6);
    step("R3", 1, 3'd6, 0, 4, 0, 4);
    for (int n = 0; n < 3; n++) step("R5", 1, 3'd2, 0, 3);
    step("R6", 1, 3'd7, 0, 6, 0, 6);
    // R9: checkerboard mask
    step("R10", 0, 3'd0, 0, 0, 0, 0, '0, 1, 16'hA5A5);
    step("R9", 1, 3'd6, 0, 0, 0, 0);
    step("R9", 1, 3'd2, 0, 1, 0, 1);
    step("R9", 1, 3'd1, 0, 0);
    step("R9", 1, 3'd3, 2'd1, 0);
    step("R9", 1, 3'd7, 0, 7, 0, 7);
    step("R9", 1, 3'd4, 0, 2);
    step("R9", 1, 3'd7, 0, 6, 0, 6, '0, 1, 16'hFFFF);  // refused, mask updates
    step("R9", 1, 3'd7, 0, 6, 0, 6);
    // R2: collisions and idle opcodes
    step("R2", 1, 3'd6, 0, 3, 1, 5, plane(9, -7));
    step("R2", 0, 3'd6, 0, 3, 0, 5);
    step("R2", 0, 3'd2, 0, 1);
    // mixed traffic
    for (int n = 0; n < 600; n++) begin
      logic [2:0] op = 3'($urandom_range(0, 7));
      int sel = $urandom_range(0, 15);
      string tg;
      case (op)
        3'd0: tg = "R2"; 3'd1: tg = "R4"; 3'd2: tg = "R5"; 3'd3: tg = "R7";
        3'd4, 3'd5: tg = "R8"; 3'd6: tg = "R3"; default: tg = "R6";
      endcase
      if (sel == 0)
        step("R10", 1, op, 2'($urandom), $urandom_range(0, 7), 1, $urandom_range(0, 7),
             {$urandom, $urandom, $urandom, $urandom});
      else if (sel == 1)
        step("R9", 1, op, 2'($urandom), $urandom_range(0, 7), 0, $urandom_range(0, 7),
             '0, 1, 16'($urandom));
      else
        step(tg, $urandom_range(0, 5) != 0, op, 2'($urandom), $urandom_range(0, 7), 0,
             $urandom_range(0, 7));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule